// File: doc/BRIEF.md
# Table-Driven Rate-1/2 Convolutional Encoder

This block encodes a serial bit stream with a rate-1/2, constraint-length-5 convolutional code. The generators are G0 = 1 + D^3 + D^4 and G1 = 1 + D + D^3 + D^4. Each accepted input bit produces one 2-bit code symbol. The modulo-2 adder trees are replaced by a small lookup structure. A four-stage history register holds the last four accepted bits. From the new bit and the history, the block forms a 1-bit row tag and a 2-bit column tag. A 2:1 row multiplexer picks one of two precomputed four-entry rows, and the column tag selects the symbol within that row.

Both the input stream and the output stream use valid/ready handshakes. An input bit is taken on a clock edge where `in_valid` and `in_ready` are both high. The symbol for that bit is presented from a register on the next cycle and is held until the consumer takes it with `out_ready`. The output register is a single stage. When that stage is full and the consumer stalls, `in_ready` falls, so back-pressure reaches the producer in the same cycle. Flushing the tail bits is left to the caller: the caller supplies zeros as ordinary inputs.

Top module: `conv_xorfree_enc`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the history register becomes all zeros and `out_valid` becomes 0. `in_ready` is 1 in the first cycle after reset.
- R2: For an accepted bit u with history h (h[0] the most recent earlier bit, h[3] the oldest), the produced symbol has `out_sym[1]` = u^h[2]^h[3] (from G0) and `out_sym[0]` = u^h[0]^h[2]^h[3] (from G1).
- R3: The history shifts only on an accepted input. On acceptance, the new h[0] is u and each older bit moves up one stage.
- R4: `out_valid` is 1 in the cycle after every accepted input. The symbol comes from a register, not from a combinational path from the input.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` high and `out_sym` unchanged.
- R6: `in_ready` is 1 exactly when the output stage is empty (`out_valid`=0) or is being drained (`out_ready`=1).
- R7: A cycle with `in_valid` low changes neither the history nor the symbol stream. The symbols that follow match a stream with that cycle removed.
- R8: The row select is h[3] and the column tag is {h[0], u^h[2]}. Row 0 maps column tags 00/01/10/11 to symbols 00/11/01/10. Row 1 maps them to 11/00/10/01. All 32 history/input combinations give the R2 symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Encoder can take an input bit this cycle |
| in_bit | input | 1 | Data bit to encode |
| out_valid | output | 1 | Output symbol register holds a symbol |
| out_ready | input | 1 | Consumer takes the symbol this cycle |
| out_sym | output | 2 | Code symbol, bit 1 from G0, bit 0 from G1 |

## Verification
The code is fixed by its polynomials, so the bench builds the block only with its default package constants: two rows of four 2-bit entries behind a four-stage history. With these values the full state space is small enough to cover completely. A directed sweep preloads each of the 16 histories, applies both input values, and compares all 32 table outputs with an XOR-form model. Random runs with input gaps and output stalls exercise the back-pressure and hold rules. All-zero and all-one streams, plus a reset in the middle of a stream, check the edges of the history.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int CONSTRAINT_LEN = 5;
  localparam int HIST_DEPTH     = CONSTRAINT_LEN - 1;
  localparam int SYM_W          = 2;
  localparam int LUT_ROWS       = 2;
  localparam int LUT_COLS       = 4;
  localparam int COL_W          = $clog2(LUT_COLS);
  localparam int ROW_W          = $clog2(LUT_ROWS);

  // history taps used to build the tags
  localparam int ROW_TAP    = HIST_DEPTH - 1;  // oldest stage selects the row
  localparam int COL_HI_TAP = 0;               // newest stage
  localparam int COL_LO_TAP = 2;               // combined with the input bit

  typedef logic [SYM_W-1:0]      sym_t;
  typedef logic [HIST_DEPTH-1:0] hist_t;
  typedef logic [COL_W-1:0]      col_t;

  // Reduced symbol table, indexed [row][column]
  localparam logic [LUT_ROWS-1:0][LUT_COLS-1:0][SYM_W-1:0] SYM_LUT = '{
    '{2'b01, 2'b10, 2'b00, 2'b11},   // row 1: col 3..0
    '{2'b10, 2'b01, 2'b11, 2'b00}    // row 0: col 3..0
  };
endpackage

// File: rtl/conv_hist_reg.sv
module conv_hist_reg
  import conv_enc_pkg::*;
#(
  parameter int DEPTH = HIST_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             din,
  output logic [DEPTH-1:0] hist
);
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (adv) begin
      hist_q <= {hist_q[DEPTH-2:0], din};
    end
  end

  assign hist = hist_q;
endmodule

// File: rtl/conv_tag_gen.sv
module conv_tag_gen
  import conv_enc_pkg::*;
#(
  parameter int DEPTH = HIST_DEPTH,
  parameter int RTAP  = ROW_TAP,
  parameter int CHTAP = COL_HI_TAP,
  parameter int CLTAP = COL_LO_TAP
) (
  input  logic             u,
  input  logic [DEPTH-1:0] hist,
  output logic             row_tag,
  output col_t             col_tag
);
  logic lo_tag;

  // inverting select: the input passes straight or inverted by one tap
  always_comb begin
    lo_tag = hist[CLTAP] ? ~u : u;
  end

  assign row_tag = hist[RTAP];
  assign col_tag = {hist[CHTAP], lo_tag};
endmodule

// File: rtl/conv_sym_lut.sv
module conv_sym_lut
  import conv_enc_pkg::*;
#(
  parameter int ROWS = LUT_ROWS,
  parameter int COLS = LUT_COLS
) (
  input  logic               row_tag,
  input  col_t               col_tag,
  output sym_t               sym
);
  sym_t row_out [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_comb begin
      row_out[r] = SYM_LUT[r][col_tag];
    end
  end

  // 2:1 row multiplexer
  always_comb begin
    sym = row_tag ? row_out[1] : row_out[0];
  end
endmodule

// File: rtl/conv_xorfree_enc.sv
module conv_xorfree_enc
  import conv_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_sym
);
  hist_t hist_q;
  logic  row_tag;
  col_t  col_tag;
  sym_t  lut_sym;
  logic  take;
  logic  vld_q;
  sym_t  sym_q;

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  conv_hist_reg #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .adv  (take),
    .din  (in_bit),
    .hist (hist_q)
  );

  conv_tag_gen #(.DEPTH(HIST_DEPTH)) u_tag (
    .u       (in_bit),
    .hist    (hist_q),
    .row_tag (row_tag),
    .col_tag (col_tag)
  );

  conv_sym_lut u_lut (
    .row_tag (row_tag),
    .col_tag (col_tag),
    .sym     (lut_sym)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      sym_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      sym_q <= lut_sym;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_sym   = sym_q;
endmodule

// File: rtl/conv_xorfree_enc_chk.sv
module conv_xorfree_enc_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_bit,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_sym,
  input logic [3:0] hist
);
  logic [3:0] m_hist;
  logic [1:0] m_exp;
  logic       m_take;

  assign m_take = in_valid && in_ready;

  // independent XOR-form model of the generators
  always_ff @(posedge clk) begin
    if (rst) begin
      m_hist <= '0;
      m_exp  <= '0;
    end else if (m_take) begin
      m_hist <= {m_hist[2:0], in_bit};
      m_exp  <= {in_bit ^ m_hist[2] ^ m_hist[3],
                 in_bit ^ m_hist[0] ^ m_hist[2] ^ m_hist[3]};
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !out_valid && hist == 4'b0000);

  a_r2_symbol_matches: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sym == m_exp);

  a_r3_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !m_take |=> $stable(hist));

  a_r3_hist_shift: assert property (@(posedge clk) disable iff (rst)
    m_take |=> hist == {$past(hist[2:0]), $past(in_bit)});

  a_r4_valid_next: assert property (@(posedge clk) disable iff (rst)
    m_take |=> out_valid);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sym));

  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  a_r6_empty_ready: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind conv_xorfree_enc conv_xorfree_enc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bit    (in_bit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sym   (out_sym),
  .hist      (hist_q)
);

// File: tb/conv_xorfree_enc_tb.sv
module conv_xorfree_enc_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic       in_bit;
  logic       out_valid;
  logic       out_ready;
  logic [1:0] out_sym;

  int total = 0;
  int bad   = 0;

  logic [3:0] ref_hist;
  logic [1:0] exp_q[$];
  logic       hold_pend;
  logic [1:0] held_sym;
  logic       take_prev;

  always #5 clk = ~clk;

  conv_xorfree_enc u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym)
  );

  function automatic logic [1:0] ref_sym(input logic u, input logic [3:0] h);
    return {u ^ h[2] ^ h[3], u ^ h[0] ^ h[2] ^ h[3]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ref_hist = '0; exp_q.delete();
    hold_pend = 1'b0; take_prev = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  // mode 0 random, 1 zeros, 2 ones, 3 five bits of word, MSB first
  task automatic run_bits(input int n, input int mode, input logic [4:0] word,
                          input int gap_pct, input int stall_pct);
    int sent = 0;
    while (sent < n || exp_q.size() > 0) begin
      @(negedge clk);
      in_valid  = (sent < n) && (($urandom % 100) >= gap_pct);
      case (mode)
        0:       in_bit = 1'($urandom & 1);
        1:       in_bit = 1'b0;
        2:       in_bit = 1'b1;
        default: in_bit = (sent < 5) ? word[4 - sent] : 1'b0;
      endcase
      out_ready = (($urandom % 100) >= stall_pct);
      #1;
      check(in_ready == (!out_valid || out_ready), "R6 in_ready",
            int'(in_ready), int'(!out_valid || out_ready));
      if (take_prev)
        check(out_valid == 1'b1, "R4 out_valid after take", int'(out_valid), 1);
      if (hold_pend) begin
        check(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
        check(out_sym == held_sym, "R5 symbol held", int'(out_sym), int'(held_sym));
      end
      hold_pend = out_valid && !out_ready;
      held_sym  = out_sym;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 R7 unexpected symbol", int'(out_sym), -1);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check(out_sym == e, (mode == 3) ? "R8 table symbol" : "R2 R7 symbol",
                int'(out_sym), int'(e));
        end
      end
      take_prev = in_valid && in_ready;
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_sym(in_bit, ref_hist));
        ref_hist = {ref_hist[2:0], in_bit};   // R3 shift order
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    take_prev = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0c0d));
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b0;
    hold_pend = 1'b0; take_prev = 1'b0; ref_hist = '0; held_sym = '0;
    repeat (3) @(posedge clk);
    do_reset();

    run_bits(40, 1, 5'd0, 0, 0);      // all zeros
    do_reset();
    run_bits(40, 2, 5'd0, 20, 20);    // all ones, steady symbol 10
    do_reset();
    run_bits(300, 0, 5'd0, 0, 0);     // random, full rate
    run_bits(800, 0, 5'd0, 35, 35);   // R7 gaps, R5 stalls
    run_bits(200, 0, 5'd0, 0, 80);    // heavy back-pressure

    // R8 exhaustive sweep: {h3,h2,h1,h0,u}
    for (int k = 0; k < 32; k++) begin
      do_reset();
      run_bits(5, 3, 5'(k), 10, 10);
    end

    // reset in the middle of a stalled stream
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R4 valid before mid reset", int'(out_valid), 1);
    do_reset();
    run_bits(60, 0, 5'd0, 10, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule